// File: doc/BRIEF.md
# Queue Depth Threshold Monitor

This block tracks how full each of a set of queues is and sorts every queue into one of four fill levels measured against a depth threshold that is programmed per queue. The queue storage lives elsewhere: the block only sees one enqueue strobe and one dequeue strobe per queue. It keeps an occupancy count for each queue and compares that count with the queue's threshold. It publishes a two-bit fill level for every queue. Each accepted dequeue also gets the fill level its queue had when the item left.

Thresholds are loaded through one write port. A write can target a single queue, an inclusive span of queue indices, or every queue at once. The comparisons use only shifts and adds, with no division. Downstream logic can use the fill levels for back-pressure, for steering work, or for tagging items with the congestion they met.

Top module: `qdt_monitor`

## Requirements
- R1: While and after reset, every occupancy count is zero and every threshold equals THR_RST. Every `bucket_o` field reads 0, and `deq_vld_o` and `underflow_o` are all low.
- R2: In one cycle, an enqueue alone adds one to the queue's count and a dequeue alone subtracts one. When both strobes are high together the count stays the same. An enqueue on a queue whose count is already 2^CNT_W-1 is dropped, unless a valid dequeue happens in the same cycle.
- R3: A dequeue on a queue whose count is zero is ignored. One cycle later, `underflow_o` for that queue pulses high for one cycle and `deq_vld_o` stays low. If an enqueue comes in the same cycle, it is still applied.
- R4: Fill level 0 means 2·count ≤ T, where T is the queue's threshold.
- R5: Fill level 1 means 2·count > T and 4·count ≤ 3·T.
- R6: Fill level 2 means 4·count > 3·T and count ≤ T.
- R7: Fill level 3 means count > T.
- R8: `bucket_o[2q+1:2q]` is registered. After a clock edge it shows queue q's count and threshold as they stand once that edge's enqueue, dequeue and threshold write have been applied.
- R9: When `thr_we` is high, `thr_mode` picks the targets. Code 0 loads `thr_val` into queue `thr_lo`. Code 1 loads every queue q with `thr_lo` ≤ q ≤ `thr_hi`, and loads none if `thr_lo` > `thr_hi`. Codes 2 and 3 load every queue.
- R10: One cycle after a dequeue is accepted on queue q, `deq_vld_o[q]` is high for one cycle. At the same time `deq_bkt_o[2q+1:2q]` holds the value `bucket_o[2q+1:2q]` had in the cycle of the dequeue.
- R11: A threshold write leaves the threshold of every queue it does not target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| enq_i | input | NQ | Enqueue strobe, one bit per queue |
| deq_i | input | NQ | Dequeue strobe, one bit per queue |
| thr_we | input | 1 | Threshold write enable |
| thr_mode | input | 2 | Write target: 0 one queue, 1 span, 2 or 3 all queues |
| thr_lo | input | QW | Target queue, or the low end of the span |
| thr_hi | input | QW | High end of the span |
| thr_val | input | THR_W | Threshold value to load |
| bucket_o | output | 2·NQ | Registered fill level per queue, two bits each |
| deq_vld_o | output | NQ | Pulse marking an accepted dequeue |
| deq_bkt_o | output | 2·NQ | Fill level attached to the dequeued item |
| underflow_o | output | NQ | Pulse marking a dequeue that hit an empty queue |

## Verification
The threshold of one queue is swept through every value its width allows. For each value the queue is filled one item at a time past saturation and then drained one item at a time past empty. This walks every level boundary exactly at 2·count = T, 4·count = 3·T and count = T, and separates strict comparisons from non-strict ones. Paired enqueue and dequeue cycles at empty, mid-fill and full separate "count held" from "count moved", and show that the underflow path differs from the accepted-dequeue path. Single-queue, span, reversed-span and all-queue writes against queues loaded to different counts show which queues a write reached and which it left untouched.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
   typedef enum logic [1:0] {
      BKT_LOW  = 2'd0,
      BKT_MID  = 2'd1,
      BKT_HIGH = 2'd2,
      BKT_OVER = 2'd3
   } qdt_bkt_e;

   localparam logic [1:0] WR_ONE  = 2'd0;
   localparam logic [1:0] WR_SPAN = 2'd1;
endpackage

// File: rtl/qdt_classify.sv
module qdt_classify #(
   parameter int CNT_W = 10,
   parameter int THR_W = 10
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [THR_W-1:0] thr,
   output qdt_pkg::qdt_bkt_e bkt
);
   localparam int MW = (CNT_W > THR_W) ? CNT_W : THR_W;
   localparam int XW = MW + 2;

   logic [XW-1:0] c1, t1, c2, c4, t3;

   always_comb begin
      c1 = {{(XW-CNT_W){1'b0}}, cnt};
      t1 = {{(XW-THR_W){1'b0}}, thr};
      c2 = c1 << 1;
      c4 = c1 << 2;
      t3 = (t1 << 1) + t1;
      if (c1 > t1)      bkt = qdt_pkg::BKT_OVER;
      else if (c4 > t3) bkt = qdt_pkg::BKT_HIGH;
      else if (c2 > t1) bkt = qdt_pkg::BKT_MID;
      else              bkt = qdt_pkg::BKT_LOW;
   end
endmodule

// File: rtl/qdt_wr_decode.sv
module qdt_wr_decode #(
   parameter int NQ = 8,
   parameter int QW = 3
) (
   input  logic          we,
   input  logic [1:0]    mode,
   input  logic [QW-1:0] lo,
   input  logic [QW-1:0] hi,
   output logic [NQ-1:0] hit
);
   for (genvar q = 0; q < NQ; q++) begin : g_q
      localparam logic [QW-1:0] QI = QW'(q);
      always_comb begin
         if (!we)                         hit[q] = 1'b0;
         else if (mode == qdt_pkg::WR_ONE)  hit[q] = (lo == QI);
         else if (mode == qdt_pkg::WR_SPAN) hit[q] = (lo <= QI) && (QI <= hi);
         else                             hit[q] = 1'b1;
      end
   end
endmodule

// File: rtl/qdt_lane.sv
module qdt_lane #(
   parameter int CNT_W   = 10,
   parameter int THR_W   = 10,
   parameter int THR_RST = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq,
   input  logic             deq,
   input  logic             thr_hit,
   input  logic [THR_W-1:0] thr_val,
   output logic [1:0]       bucket,
   output logic             deq_vld,
   output logic [1:0]       deq_bkt,
   output logic             underflow
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [THR_W-1:0] TRST = THR_W'(THR_RST);

   logic [CNT_W-1:0] cnt, cnt_nx;
   logic [THR_W-1:0] thr, thr_nx;
   logic             inc, dec;
   qdt_pkg::qdt_bkt_e bkt_nx;

   always_comb begin
      dec    = deq && (cnt != '0);
      inc    = enq && ((cnt != CMAX) || dec);
      thr_nx = thr_hit ? thr_val : thr;
      case ({inc, dec})
         2'b10:   cnt_nx = cnt + CNT_W'(1);
         2'b01:   cnt_nx = cnt - CNT_W'(1);
         default: cnt_nx = cnt;
      endcase
   end

   qdt_classify #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cls (
      .cnt(cnt_nx),
      .thr(thr_nx),
      .bkt(bkt_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         thr       <= TRST;
         bucket    <= 2'd0;
         deq_vld   <= 1'b0;
         deq_bkt   <= 2'd0;
         underflow <= 1'b0;
      end else begin
         cnt       <= cnt_nx;
         thr       <= thr_nx;
         bucket    <= bkt_nx;
         deq_vld   <= dec;
         underflow <= deq && (cnt == '0);
         if (dec) deq_bkt <= bucket;
      end
   end
endmodule

// File: rtl/qdt_monitor.sv
module qdt_monitor #(
   parameter int NQ      = 8,
   parameter int CNT_W   = 10,
   parameter int THR_W   = 10,
   parameter int THR_RST = 512,
   parameter int QW      = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NQ-1:0]   enq_i,
   input  logic [NQ-1:0]   deq_i,
   input  logic            thr_we,
   input  logic [1:0]      thr_mode,
   input  logic [QW-1:0]   thr_lo,
   input  logic [QW-1:0]   thr_hi,
   input  logic [THR_W-1:0] thr_val,
   output logic [2*NQ-1:0] bucket_o,
   output logic [NQ-1:0]   deq_vld_o,
   output logic [2*NQ-1:0] deq_bkt_o,
   output logic [NQ-1:0]   underflow_o
);
   if (NQ < 1) begin : g_bad_nq
      $error("qdt_monitor: NQ must be at least 1");
   end
   if (CNT_W < 1 || THR_W < 1) begin : g_bad_w
      $error("qdt_monitor: widths must be at least 1");
   end
   if (THR_RST < 0 || THR_RST >= (1 << THR_W)) begin : g_bad_rst
      $error("qdt_monitor: THR_RST does not fit THR_W");
   end
   if ((1 << QW) < NQ) begin : g_bad_qw
      $error("qdt_monitor: QW too narrow for NQ");
   end

   logic [NQ-1:0] hit;

   qdt_wr_decode #(.NQ(NQ), .QW(QW)) u_dec (
      .we  (thr_we),
      .mode(thr_mode),
      .lo  (thr_lo),
      .hi  (thr_hi),
      .hit (hit)
   );

   for (genvar q = 0; q < NQ; q++) begin : g_lane
      qdt_lane #(.CNT_W(CNT_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .enq      (enq_i[q]),
         .deq      (deq_i[q]),
         .thr_hit  (hit[q]),
         .thr_val  (thr_val),
         .bucket   (bucket_o[2*q +: 2]),
         .deq_vld  (deq_vld_o[q]),
         .deq_bkt  (deq_bkt_o[2*q +: 2]),
         .underflow(underflow_o[q])
      );
   end
endmodule

// File: rtl/qdt_monitor_chk.sv
module qdt_monitor_chk #(
   parameter int NQ = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NQ-1:0]   enq_i,
   input logic [NQ-1:0]   deq_i,
   input logic            thr_we,
   input logic [2*NQ-1:0] bucket_o,
   input logic [NQ-1:0]   deq_vld_o,
   input logic [2*NQ-1:0] deq_bkt_o,
   input logic [NQ-1:0]   underflow_o
);
   for (genvar q = 0; q < NQ; q++) begin : g_q
      assert_deq_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
         deq_vld_o[q] |-> (deq_bkt_o[2*q +: 2] == $past(bucket_o[2*q +: 2])));

      assert_vld_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
         deq_vld_o[q] |-> $past(deq_i[q]));

      assert_uflow_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
         underflow_o[q] |-> ($past(deq_i[q]) && ($past(bucket_o[2*q +: 2]) == 2'd0)
                             && !deq_vld_o[q]));

      assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!enq_i[q] && !deq_i[q] && !thr_we) |=> $stable(bucket_o[2*q +: 2]));

      assert_enq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (enq_i[q] && !deq_i[q] && !thr_we) |=>
            (bucket_o[2*q +: 2] >= $past(bucket_o[2*q +: 2])));

      assert_deq_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (deq_i[q] && !enq_i[q] && !thr_we) |=>
            (bucket_o[2*q +: 2] <= $past(bucket_o[2*q +: 2])));
   end
endmodule

bind qdt_monitor qdt_monitor_chk #(.NQ(NQ)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enq_i      (enq_i),
   .deq_i      (deq_i),
   .thr_we     (thr_we),
   .bucket_o   (bucket_o),
   .deq_vld_o  (deq_vld_o),
   .deq_bkt_o  (deq_bkt_o),
   .underflow_o(underflow_o)
);

// File: tb/qdt_monitor_test.sv
`timescale 1ns/1ps
module qdt_monitor_test;
   localparam int NQ = 4, CW = 5, TW = 5, TRST = 16, QW = 2;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NQ-1:0] enq_i = '0, deq_i = '0;
   logic thr_we = 1'b0;
   logic [1:0] thr_mode = 2'd0;
   logic [QW-1:0] thr_lo = '0, thr_hi = '0;
   logic [TW-1:0] thr_val = '0;
   logic [2*NQ-1:0] bucket_o, deq_bkt_o;
   logic [NQ-1:0] deq_vld_o, underflow_o;

   int checks = 0, failures = 0, cycles = 0;
   int mcnt[NQ], mthr[NQ];

   always #2 clk = ~clk;

   qdt_monitor #(.NQ(NQ), .CNT_W(CW), .THR_W(TW), .THR_RST(TRST)) uut (
      .clk(clk), .rst_n(rst_n), .enq_i(enq_i), .deq_i(deq_i),
      .thr_we(thr_we), .thr_mode(thr_mode), .thr_lo(thr_lo), .thr_hi(thr_hi),
      .thr_val(thr_val), .bucket_o(bucket_o), .deq_vld_o(deq_vld_o),
      .deq_bkt_o(deq_bkt_o), .underflow_o(underflow_o)
   );

   function automatic int exp_bkt(int c, int t);
      if (c > t)             return 3;
      else if (4 * c > 3 * t) return 2;
      else if (2 * c > t)     return 1;
      else                    return 0;
   endfunction

   function automatic string bkt_tag(int b);
      case (b)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, apply model, check just after the edge
   task automatic cyc(logic [NQ-1:0] e, logic [NQ-1:0] d, logic we, logic [1:0] mode,
                      int lo, int hi, int tv, string ctx);
      int ev[NQ], eb[NQ], eu[NQ];
      @(negedge clk);
      enq_i = e; deq_i = d; thr_we = we; thr_mode = mode;
      thr_lo = QW'(lo); thr_hi = QW'(hi); thr_val = TW'(tv);
      @(posedge clk);
      for (int q = 0; q < NQ; q++) begin
         int old = mcnt[q];
         int dc = (d[q] && old > 0) ? 1 : 0;
         int ic = (e[q] && (old < CMAX || dc == 1)) ? 1 : 0;
         int hitq;
         ev[q] = dc;
         eb[q] = exp_bkt(old, mthr[q]);
         eu[q] = (d[q] && old == 0) ? 1 : 0;
         if (!we) hitq = 0;
         else if (mode == 2'd0) hitq = (q == lo);
         else if (mode == 2'd1) hitq = (lo <= q && q <= hi);
         else hitq = 1;
         mcnt[q] = old + ic - dc;
         if (hitq != 0) mthr[q] = tv;
      end
      #1;
      for (int q = 0; q < NQ; q++) begin
         int b = exp_bkt(mcnt[q], mthr[q]);
         check({bkt_tag(b), " R8 ", ctx}, int'(bucket_o[2*q +: 2]), b);
         check({"R10 vld ", ctx}, int'(deq_vld_o[q]), ev[q]);
         if (ev[q] != 0) check({"R10 tag ", ctx}, int'(deq_bkt_o[2*q +: 2]), eb[q]);
         check({"R3 underflow ", ctx}, int'(underflow_o[q]), eu[q]);
      end
   endtask

   task automatic idle(string ctx);
      cyc('0, '0, 1'b0, 2'd0, 0, 0, 0, ctx);
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) begin mcnt[q] = 0; mthr[q] = TRST; end
      repeat (3) @(posedge clk);
      #1;
      for (int q = 0; q < NQ; q++) begin
         check("R1 bucket in reset", int'(bucket_o[2*q +: 2]), 0);
         check("R1 vld in reset", int'(deq_vld_o[q]), 0);
         check("R1 underflow in reset", int'(underflow_o[q]), 0);
      end
      @(negedge clk); rst_n = 1'b1;
      idle("R1 after reset");
      // R3: dequeue on every empty queue, then enqueue+dequeue on empty
      cyc('0, '1, 1'b0, 2'd0, 0, 0, 0, "R3 empty deq");
      cyc(4'b0001, 4'b0001, 1'b0, 2'd0, 0, 0, 0, "R3 enq with empty deq");
      cyc('0, 4'b0001, 1'b0, 2'd0, 0, 0, 0, "R2 drain");
      // sweep every threshold on queue 0, filling past saturation and draining past empty
      for (int t = 0; t <= CMAX; t++) begin
         cyc('0, '0, 1'b1, 2'd0, 0, 0, t, "R9 R11 single write");
         for (int k = 0; k <= CMAX; k++)
            cyc(4'b0001, '0, 1'b0, 2'd0, 0, 0, 0, "R2 fill");
         cyc(4'b0001, 4'b0001, 1'b0, 2'd0, 0, 0, 0, "R2 both at full");
         for (int k = 0; k <= CMAX + 1; k++)
            cyc('0, 4'b0001, 1'b0, 2'd0, 0, 0, 0, "R2 drain");
      end
      // different counts per queue, then span, reversed span, all, single writes
      for (int k = 0; k < 12; k++)
         cyc({1'b1, k < 9, k < 6, k < 3}, '0, 1'b0, 2'd0, 0, 0, 0, "R2 load");
      cyc('0, '0, 1'b1, 2'd1, 1, 2, 8, "R9 R11 span");
      cyc('0, '0, 1'b1, 2'd1, 3, 1, 0, "R9 R11 reversed span");
      cyc('0, '0, 1'b1, 2'd2, 0, 0, 10, "R9 all mode2");
      cyc('0, '0, 1'b1, 2'd3, 0, 0, 7, "R9 all mode3");
      cyc('0, '0, 1'b1, 2'd0, 3, 0, 4, "R9 R11 single q3");
      cyc(4'b1010, 4'b0110, 1'b1, 2'd1, 2, 3, 15, "R2 R9 mixed");
      cyc(4'b1111, 4'b1111, 1'b0, 2'd0, 0, 0, 0, "R2 both mid");
      idle("R8 idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end
endmodule